// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits between a single-hart core's memory port and a word-addressed memory. It lets the core build atomic read-modify-write sequences from a reserving load and a conditional store. A reserving load reads a word and notes its word address as reserved. A conditional store writes only when that reservation is still intact. It reports 0 when it succeeds and a fixed non-zero code when it fails. Software loops on that code until it gets 0.

The reservation is held as a valid flag and a word address. It is broken by three things: a plain store from the core to any byte of the reserved word, a write to that word by another agent (seen on the snoop input), and any conditional store. Plain loads and stores pass straight through to memory. Each request gets exactly one response on the following cycle. For loads, the response data is the memory read data, since memory answers one cycle after the read strobe.

Request opcodes: 0 = plain load, 1 = plain store, 2 = reserving load, 3 = conditional store.

Top module: `lrsc_monitor`

## Requirements
- R1: Every accepted request (req_valid high) yields rsp_valid high on the next cycle and only then. For opcodes 0 and 2, rsp_data equals the memory word at req_addr.
- R2: A conditional store (opcode 3) whose word address equals the live reservation writes req_wdata to memory and returns rsp_data = 0.
- R3: A failing conditional store returns rsp_data = 1 and leaves memory unchanged.
- R4: Every conditional store, whether it succeeds or fails, clears the reservation, so an immediately repeated one fails.
- R5: A plain store (opcode 1) to any byte of the reserved word clears the reservation. A plain store to another word does not.
- R6: A snooped external write to the reserved word (snoop_word = req_addr[AW-1:2] of the reserving load) clears the reservation. One to another word does not.
- R7: A conditional store to a word other than the reserved one fails, and the reservation is cleared.
- R8: A newer reserving load replaces the older reservation, so a conditional store to the older word fails.
- R9: A snooped write to the same word in the same cycle as a conditional store makes it fail. One in the same cycle as a reserving load leaves no reservation.
- R10: Reset clears the reservation and rsp_valid, so a conditional store issued first after reset fails.
- R11: Plain loads and stores reach memory unchanged, and a plain store returns rsp_data = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request strobe |
| req_op | input | 2 | Opcode: 0 load, 1 store, 2 reserving load, 3 conditional store |
| req_addr | input | AW | Byte address (rs1) |
| req_wdata | input | DW | Store data (rs2) |
| snoop_valid | input | 1 | Another agent writes memory this cycle |
| snoop_word | input | AW-2 | Word address of that external write |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after mem_re |
| rsp_valid | output | 1 | Response strobe (rd write) |
| rsp_data | output | DW | Load data or conditional-store status |

## Verification
The hardest situations to reach are the same-cycle collisions. In these, an external write lands on the reserved word in exactly the cycle when a conditional store or a reserving load is presented. The bench's transaction task drives the snoop strobe and the core request together on one falling edge, so both are sampled at the same rising edge. After each collision, a plain load reads back memory, which shows whether the conditional store wrote. A follow-up conditional store then shows whether any reservation survived.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int FAIL_CODE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          snoop_valid,
  input  logic [AW-3:0] snoop_word,
  output logic          mem_re,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam int WW = AW - 2;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LR = 2'd2, OP_SC = 2'd3;

  logic          resv_valid;
  logic [WW-1:0] resv_word;
  logic          rsp_from_mem;
  logic [DW-1:0] rsp_code;

  wire [WW-1:0] req_word = req_addr[AW-1:2];
  wire is_ld = req_valid && req_op == OP_LD;
  wire is_st = req_valid && req_op == OP_ST;
  wire is_lr = req_valid && req_op == OP_LR;
  wire is_sc = req_valid && req_op == OP_SC;

  wire snoop_on_req  = snoop_valid && snoop_word == req_word;
  wire snoop_on_resv = snoop_valid && snoop_word == resv_word;
  wire req_on_resv   = resv_word == req_word;
  wire sc_ok         = is_sc && resv_valid && req_on_resv && !snoop_on_req;

  assign mem_re    = is_ld || is_lr;
  assign mem_we    = is_st || sc_ok;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign rsp_data  = rsp_from_mem ? mem_rdata : rsp_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_valid <= 1'b0;
      resv_word  <= '0;
    end else if (is_lr) begin
      resv_valid <= !snoop_on_req;
      resv_word  <= req_word;
    end else if (is_sc || (is_st && req_on_resv) || snoop_on_resv) begin
      resv_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_from_mem <= 1'b0;
      rsp_code     <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_from_mem <= mem_re;
      rsp_code     <= (is_sc && !sc_ok) ? DW'(FAIL_CODE) : '0;
    end
  end
endmodule

// File: rtl/lrsc_monitor_checker.sv
module lrsc_monitor_checker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int FAIL_CODE = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic [AW-3:0] req_word,
  input logic          snoop_valid,
  input logic [AW-3:0] snoop_word,
  input logic          mem_we,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          resv_valid,
  input logic [AW-3:0] resv_word
);
  wire sc = req_valid && req_op == 2'd3;

  assert_rsp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_sc_success_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sc && mem_we) |=> rsp_data == '0);
  assert_sc_fail_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc && !mem_we) |=> rsp_data == DW'(FAIL_CODE));
  assert_sc_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sc |=> !resv_valid);
  assert_snoop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_valid && snoop_valid && snoop_word == resv_word &&
     !(req_valid && req_op == 2'd2)) |=> !resv_valid);
  assert_sc_other_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sc && (!resv_valid || req_word != resv_word)) |-> !mem_we);
endmodule

bind lrsc_monitor lrsc_monitor_checker #(.AW(AW), .DW(DW), .FAIL_CODE(FAIL_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_word(req_addr[AW-1:2]), .snoop_valid(snoop_valid), .snoop_word(snoop_word),
  .mem_we(mem_we), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .resv_valid(resv_valid), .resv_word(resv_word)
);

// File: tb/test_lrsc_monitor.sv
`timescale 1ns/100ps
module test_lrsc_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        snoop_valid = 1'b0;
  logic [29:0] snoop_word = '0;
  logic [31:0] snoop_data = '0;
  logic        mem_re, mem_we;
  logic [31:0] mem_addr, mem_wdata, rsp_data;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [31:0] mem [16];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  lrsc_monitor i_lrsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
    .snoop_word(snoop_word), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always @(posedge clk) begin
    if (snoop_valid) mem[snoop_word[3:0]] <= snoop_data;
    if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[5:2]];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xact(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                      input logic sv, input logic [29:0] sw, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    snoop_valid = sv; snoop_word = sw; snoop_data = 32'hE0E0_0000 | {2'b0, sw};
    @(posedge clk); #1;
    r = rsp_data;
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    req_valid = 1'b0; snoop_valid = 1'b0;
  endtask

  task automatic lr(input logic [31:0] a, output logic [31:0] r);
    xact(2'd2, a, '0, 1'b0, '0, r);
  endtask
  task automatic ld(input logic [31:0] a, output logic [31:0] r);
    xact(2'd0, a, '0, 1'b0, '0, r);
  endtask
  task automatic st(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] r;
    xact(2'd1, a, d, 1'b0, '0, r);
    check("R11 store rsp", r, 32'd0);
  endtask
  task automatic sc(input logic [31:0] a, input logic [31:0] d, output logic [31:0] r);
    xact(2'd3, a, d, 1'b0, '0, r);
  endtask
  task automatic snoop(input logic [29:0] w);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_word = w; snoop_data = 32'hE0E0_0000 | {2'b0, w};
    @(posedge clk); #1;
    snoop_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    check("R10 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    sc(32'h10, 32'hDEAD, r);
    check("R10 sc after reset fails", r, 32'd1);
    ld(32'h10, r);
    check("R10 memory untouched", r, 32'h0000_0104);
  endtask

  task automatic t_basic;
    logic [31:0] r;
    lr(32'h20, r);
    check("R1 lr data", r, 32'h0000_0108);
    sc(32'h20, 32'hA5A5_0001, r);
    check("R2 sc success code", r, 32'd0);
    ld(32'h20, r);
    check("R2 sc wrote", r, 32'hA5A5_0001);
    sc(32'h20, 32'hBAD0_0001, r);
    check("R4 repeat sc fails", r, 32'd1);
    ld(32'h20, r);
    check("R3 failed sc no write", r, 32'hA5A5_0001);
  endtask

  task automatic t_local_store;
    logic [31:0] r;
    lr(32'h24, r);
    st(32'h26, 32'h1111_2222);
    sc(32'h24, 32'hBAD0_0002, r);
    check("R5 store same word breaks", r, 32'd1);
    ld(32'h24, r);
    check("R5 store value kept", r, 32'h1111_2222);
    lr(32'h24, r);
    st(32'h28, 32'h3333_4444);
    sc(32'h27, 32'h5555_6666, r);
    check("R5 store other word harmless", r, 32'd0);
    ld(32'h24, r);
    check("R11 plain load", r, 32'h5555_6666);
  endtask

  task automatic t_snoop;
    logic [31:0] r;
    lr(32'h30, r);
    snoop(30'hC);
    sc(32'h30, 32'hBAD0_0003, r);
    check("R6 snoop same word breaks", r, 32'd1);
    ld(32'h30, r);
    check("R6 external value kept", r, 32'hE0E0_000C);
    lr(32'h30, r);
    snoop(30'hD);
    sc(32'h30, 32'h7777_0001, r);
    check("R6 snoop other word harmless", r, 32'd0);
  endtask

  task automatic t_other_word;
    logic [31:0] r;
    lr(32'h08, r);
    sc(32'h0C, 32'hBAD0_0004, r);
    check("R7 sc other word fails", r, 32'd1);
    ld(32'h0C, r);
    check("R7 other word unchanged", r, 32'h0000_0103);
    sc(32'h08, 32'hBAD0_0005, r);
    check("R7 reservation cleared", r, 32'd1);
  endtask

  task automatic t_replace;
    logic [31:0] r;
    lr(32'h00, r);
    lr(32'h04, r);
    sc(32'h00, 32'hBAD0_0006, r);
    check("R8 old reservation gone", r, 32'd1);
    lr(32'h00, r);
    lr(32'h04, r);
    sc(32'h04, 32'h8888_0001, r);
    check("R8 newest reservation live", r, 32'd0);
  endtask

  task automatic t_collide;
    logic [31:0] r;
    lr(32'h34, r);
    xact(2'd3, 32'h34, 32'hBAD0_0007, 1'b1, 30'hD, r);
    check("R9 snoop with sc fails", r, 32'd1);
    ld(32'h34, r);
    check("R9 external write kept", r, 32'hE0E0_000D);
    xact(2'd2, 32'h38, '0, 1'b1, 30'hE, r);
    sc(32'h38, 32'hBAD0_0008, r);
    check("R9 snoop with lr no reservation", r, 32'd1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h100 + i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_basic;
    t_local_store;
    t_snoop;
    t_other_word;
    t_replace;
    t_collide;
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule